// File: doc/BRIEF.md
# Buried-Register Diagnostic Readout Controller

This block gives a production tester a way to look inside a logic sequencer's hidden registers one bit at a time without disturbing them. The readable set holds eighteen bits: the sixteen feedback state bits and the two complemented sum-term values. Three select lines pick the bit. Each line carries one of three levels: low, high or extra-high. The chosen bit comes out on a single readout line.

Readout is allowed only after a fixed entry order. First the tester raises the output-disable pin. Then it drives the arm line to the extra-high level. Only then does the address count. Each step must be held for a minimum number of clock edges before the next step is taken. When the disable pin also serves as an ordinary array input, the auxiliary guard line must already be at extra-high when the disable pin rises.

An entry step taken out of order, or too early, sets a sticky error flag and sends the controller back to its start. While the controller is armed it raises a hold output that freezes the sequencer's registers. The read path is purely combinational over the live register bits.

Each three-level line is modelled as a 2-bit code, with no analog level sensing.

Top module: `diag_readout_ctrl`

## Requirements
- R1: After reset, entry_step is 0 (Idle), protocol_error is 0, and read_valid, read_bit and state_hold are all 0.
- R2: In Idle, with oe_pin high and oe_shared low, the next clock edge moves entry_step to 1 (OutputsOff). This transition is named Disable.
- R3: In OutputsOff, with oe_pin held high for at least MIN_GAP edges, q0_lvl = 2'b10 (extra-high) moves entry_step to 2 (Armed) at the next edge. This transition is named Arm. state_hold is 1 exactly while entry_step is 2.
- R4: read_valid goes high once Armed has lasted MIN_GAP edges. While read_valid is 0, read_bit is 0.
- R5: Level codes are 2'b00 low = digit 0, 2'b01 high = digit 1 and 2'b10 extra-high = digit 2. sel_lvl[5:4] is the most significant digit and sel_lvl[1:0] the least. Address 0 reads cterm_bits[1], 1 reads state_bits[15], 2 reads cterm_bits[0], 3 reads state_bits[14], and addresses 4 to 17 read state_bits[0] to state_bits[13].
- R6: Addresses 18 to 26 read 0.
- R7: q0_lvl at extra-high while in Idle is a protocol violation. protocol_error is set at the next edge and entry_step stays 0.
- R8: Arming in OutputsOff before MIN_GAP edges have passed is a violation. The error is set and entry_step returns to 0. This transition is named EarlyArm.
- R9: When oe_shared is 1, raising oe_pin in Idle while i5_lvl is not 2'b10 is a violation. When i5_lvl is 2'b10, the Disable transition proceeds with no error.
- R10: In Armed, a select line at code 2'b11 is a violation (transition BadLevel). The error is set, entry_step returns to 0, and read_bit is 0 in that cycle.
- R11: oe_pin going low in OutputsOff or Armed, or q0_lvl leaving extra-high in Armed, returns entry_step to 0 without error. This transition is named Abort.
- R12: protocol_error stays set until reset, and the entry sequence still works while it is set.
- R13: While Armed, read_bit follows sel_lvl, state_bits and cterm_bits in the same cycle, and entry_step does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| oe_pin | input | 1 | Output-disable pin; high disables the outputs |
| oe_shared | input | 1 | Set when the disable pin is also an array input |
| i5_lvl | input | 2 | Level on the guard line |
| q0_lvl | input | 2 | Level on the arm line |
| sel_lvl | input | 6 | Three select levels, most significant digit at the top |
| state_bits | input | 16 | Live state register bits |
| cterm_bits | input | 2 | Live complemented sum-term bits |
| entry_step | output | 2 | 0 Idle, 1 OutputsOff, 2 Armed |
| state_hold | output | 1 | Freezes the sequencer registers |
| read_valid | output | 1 | Readout is meaningful |
| read_bit | output | 1 | Selected buried bit |
| protocol_error | output | 1 | Sticky entry-order violation |

## Verification
Step changes and error setting come from registers, so they are due at the first rising edge after the stimulus. The bench changes inputs on a falling edge and checks them on the next falling edge. read_valid appears MIN_GAP edges after the Arm edge, so the bench waits MIN_GAP+1 falling edges after driving the arm level. The readout bit is combinational, so it is checked in the same half-cycle as a select or data change, after a 1 ns settle. The driver queues the expected values and the monitor compares them only after that settle.

// File: rtl/diag_pkg.sv
package diag_pkg;

    typedef enum logic [1:0] {
        LVL_LOW   = 2'b00,
        LVL_HIGH  = 2'b01,
        LVL_XHIGH = 2'b10,
        LVL_BAD   = 2'b11
    } lvl_e;

    typedef enum logic [1:0] {
        STEP_IDLE    = 2'd0,
        STEP_OUT_OFF = 2'd1,
        STEP_ARMED   = 2'd2
    } step_e;

    function automatic int pow3(input int n);
        int r;
        r = 1;
        for (int i = 0; i < n; i++) r = r * 3;
        return r;
    endfunction

endpackage

// File: rtl/diag_addr_decode.sv
module diag_addr_decode
    import diag_pkg::*;
#(
    parameter int DIGITS   = 3,
    parameter int NUM_BITS = 18,
    parameter int IDX_W    = 5
) (
    input  logic [2*DIGITS-1:0] sel_lvl,
    output logic [IDX_W-1:0]    idx,
    output logic                idx_ok
);
    logic [DIGITS-1:0] dig_ok;
    logic [IDX_W-1:0]  dig_term [DIGITS];
    logic [IDX_W-1:0]  sum;

    generate
        for (genvar g = 0; g < DIGITS; g++) begin : g_digit
            localparam int WEIGHT = pow3(g);
            assign dig_ok[g]   = (sel_lvl[2*g +: 2] != LVL_BAD);
            assign dig_term[g] = dig_ok[g] ? IDX_W'(WEIGHT * int'(sel_lvl[2*g +: 2])) : '0;
        end
    endgenerate

    always_comb begin
        sum = '0;
        for (int g = 0; g < DIGITS; g++) sum = sum + dig_term[g];
    end

    assign idx    = sum;
    assign idx_ok = (&dig_ok) && (int'(sum) < NUM_BITS);
endmodule

// File: rtl/diag_bit_mux.sv
module diag_bit_mux #(
    parameter int STATE_W  = 16,
    parameter int CTERM_W  = 2,
    parameter int NUM_BITS = STATE_W + CTERM_W,
    parameter int IDX_W    = 5
) (
    input  logic [STATE_W-1:0] state_bits,
    input  logic [CTERM_W-1:0] cterm_bits,
    input  logic [IDX_W-1:0]   idx,
    input  logic               idx_ok,
    output logic               bit_out
);
    logic [NUM_BITS-1:0] view;

    generate
        for (genvar k = 0; k < NUM_BITS; k++) begin : g_slot
            if (k == 0) begin : g_c1
                assign view[k] = cterm_bits[1];
            end else if (k == 1) begin : g_ptop
                assign view[k] = state_bits[STATE_W-1];
            end else if (k == 2) begin : g_c0
                assign view[k] = cterm_bits[0];
            end else if (k == 3) begin : g_pnext
                assign view[k] = state_bits[STATE_W-2];
            end else begin : g_plow
                assign view[k] = state_bits[k-4];
            end
        end
    endgenerate

    assign bit_out = idx_ok & view[idx];
endmodule

// File: rtl/diag_gap_timer.sv
module diag_gap_timer #(
    parameter int MIN_GAP = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic done
);
    localparam int CNT_W = $clog2(MIN_GAP + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MIN_GAP);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (restart)      cnt <= '0;
        else if (cnt != LIMIT) cnt <= cnt + 1'b1;
    end

    assign done = (cnt == LIMIT);
endmodule

// File: rtl/diag_entry_fsm.sv
module diag_entry_fsm
    import diag_pkg::*;
#(
    parameter int DIGITS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                oe_pin,
    input  logic                oe_shared,
    input  logic [1:0]          i5_lvl,
    input  logic [1:0]          q0_lvl,
    input  logic [2*DIGITS-1:0] sel_lvl,
    input  logic                gap_done,
    output step_e               step,
    output logic                step_change,
    output logic                err
);
    step_e st_q, st_d;
    logic  viol;
    logic  sel_bad;
    logic  q0_x;

    assign q0_x = (q0_lvl == LVL_XHIGH);

    always_comb begin
        sel_bad = 1'b0;
        for (int g = 0; g < DIGITS; g++)
            if (sel_lvl[2*g +: 2] == LVL_BAD) sel_bad = 1'b1;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= STEP_IDLE;
        else        st_q <= st_d;
    end

    // transitions: Disable, Arm, EarlyArm, BadLevel, Abort
    always_comb begin
        st_d = st_q;
        viol = 1'b0;
        unique case (st_q)
            STEP_IDLE: begin
                if (q0_x) begin
                    viol = 1'b1;
                end else if (oe_pin) begin
                    if (oe_shared && (i5_lvl != LVL_XHIGH)) viol = 1'b1;
                    else                                    st_d = STEP_OUT_OFF;
                end
            end
            STEP_OUT_OFF: begin
                if (!oe_pin) begin
                    st_d = STEP_IDLE;
                end else if (q0_x) begin
                    if (gap_done) begin
                        st_d = STEP_ARMED;
                    end else begin
                        viol = 1'b1;
                        st_d = STEP_IDLE;
                    end
                end
            end
            STEP_ARMED: begin
                if (!oe_pin || !q0_x) begin
                    st_d = STEP_IDLE;
                end else if (sel_bad) begin
                    viol = 1'b1;
                    st_d = STEP_IDLE;
                end
            end
            default: st_d = STEP_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    err <= 1'b0;
        else if (viol) err <= 1'b1;
    end

    assign step        = st_q;
    assign step_change = (st_d != st_q);
endmodule

// File: rtl/diag_readout_ctrl.sv
module diag_readout_ctrl
    import diag_pkg::*;
#(
    parameter int STATE_W    = 16,
    parameter int CTERM_W    = 2,
    parameter int SEL_DIGITS = 3,
    parameter int MIN_GAP    = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    oe_pin,
    input  logic                    oe_shared,
    input  logic [1:0]              i5_lvl,
    input  logic [1:0]              q0_lvl,
    input  logic [2*SEL_DIGITS-1:0] sel_lvl,
    input  logic [STATE_W-1:0]      state_bits,
    input  logic [CTERM_W-1:0]      cterm_bits,
    output logic [1:0]              entry_step,
    output logic                    state_hold,
    output logic                    read_valid,
    output logic                    read_bit,
    output logic                    protocol_error
);
    localparam int NUM_BITS = STATE_W + CTERM_W;
    localparam int MAX_CODE = pow3(SEL_DIGITS);
    localparam int IDX_W    = $clog2(MAX_CODE);

    step_e            step;
    logic             step_change;
    logic             gap_done;
    logic [IDX_W-1:0] idx;
    logic             idx_ok;
    logic             mux_bit;

    diag_entry_fsm #(.DIGITS(SEL_DIGITS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .oe_pin      (oe_pin),
        .oe_shared   (oe_shared),
        .i5_lvl      (i5_lvl),
        .q0_lvl      (q0_lvl),
        .sel_lvl     (sel_lvl),
        .gap_done    (gap_done),
        .step        (step),
        .step_change (step_change),
        .err         (protocol_error)
    );

    diag_gap_timer #(.MIN_GAP(MIN_GAP)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (step_change),
        .done    (gap_done)
    );

    diag_addr_decode #(.DIGITS(SEL_DIGITS), .NUM_BITS(NUM_BITS), .IDX_W(IDX_W)) u_dec (
        .sel_lvl (sel_lvl),
        .idx     (idx),
        .idx_ok  (idx_ok)
    );

    diag_bit_mux #(.STATE_W(STATE_W), .CTERM_W(CTERM_W), .NUM_BITS(NUM_BITS), .IDX_W(IDX_W)) u_mux (
        .state_bits (state_bits),
        .cterm_bits (cterm_bits),
        .idx        (idx),
        .idx_ok     (idx_ok),
        .bit_out    (mux_bit)
    );

    assign entry_step = step;
    assign state_hold = (step == STEP_ARMED);
    assign read_valid = (step == STEP_ARMED) && gap_done;
    assign read_bit   = read_valid & mux_bit;
endmodule

// File: rtl/diag_readout_checker.sv
module diag_readout_checker #(
    parameter int STATE_W    = 16,
    parameter int CTERM_W    = 2,
    parameter int SEL_DIGITS = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    oe_pin,
    input logic                    oe_shared,
    input logic [1:0]              i5_lvl,
    input logic [1:0]              q0_lvl,
    input logic [2*SEL_DIGITS-1:0] sel_lvl,
    input logic [1:0]              entry_step,
    input logic                    state_hold,
    input logic                    read_valid,
    input logic                    read_bit,
    input logic                    protocol_error
);
    assert_step_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        entry_step != 2'd3);

    assert_arm_from_outoff_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_step == 2'd1 && oe_pin && q0_lvl != 2'b10) |=> entry_step != 2'd2);

    assert_hold_when_armed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_step == 2'd1 && oe_pin && q0_lvl == 2'b10) |=> (state_hold || protocol_error));

    assert_valid_needs_armed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        read_valid |-> state_hold);

    assert_bit_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !read_valid |-> !read_bit);

    assert_idle_arm_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_step == 2'd0 && q0_lvl == 2'b10) |=> (protocol_error && entry_step == 2'd0));

    assert_shared_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_step == 2'd0 && oe_pin && oe_shared && i5_lvl != 2'b10) |=> (protocol_error && entry_step == 2'd0));

    assert_abort_on_oe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_step != 2'd0 && !oe_pin) |=> entry_step == 2'd0);

    assert_error_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        protocol_error |=> protocol_error);
endmodule

bind diag_readout_ctrl diag_readout_checker #(
    .STATE_W(STATE_W), .CTERM_W(CTERM_W), .SEL_DIGITS(SEL_DIGITS)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .oe_pin         (oe_pin),
    .oe_shared      (oe_shared),
    .i5_lvl         (i5_lvl),
    .q0_lvl         (q0_lvl),
    .sel_lvl        (sel_lvl),
    .entry_step     (entry_step),
    .state_hold     (state_hold),
    .read_valid     (read_valid),
    .read_bit       (read_bit),
    .protocol_error (protocol_error)
);

// File: tb/sim_diag_readout_ctrl.sv
module sim_diag_readout_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int G = 4;

    localparam int F_STEP = 0, F_VALID = 1, F_BIT = 2, F_HOLD = 3, F_ERR = 4;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        oe_pin = 0, oe_shared = 0;
    logic [1:0]  i5_lvl = 0, q0_lvl = 0;
    logic [5:0]  sel_lvl = 0;
    logic [15:0] state_bits = 0;
    logic [1:0]  cterm_bits = 0;
    logic [1:0]  entry_step;
    logic        state_hold, read_valid, read_bit, protocol_error;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    typedef struct {
        string req;
        int    field;
        int    exp;
    } item_t;
    item_t pend[$];
    event  chk_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    diag_readout_ctrl #(.MIN_GAP(G)) u0 (
        .clk(clk), .rst_n(rst_n), .oe_pin(oe_pin), .oe_shared(oe_shared),
        .i5_lvl(i5_lvl), .q0_lvl(q0_lvl), .sel_lvl(sel_lvl),
        .state_bits(state_bits), .cterm_bits(cterm_bits),
        .entry_step(entry_step), .state_hold(state_hold), .read_valid(read_valid),
        .read_bit(read_bit), .protocol_error(protocol_error)
    );

    function automatic int field_val(int f);
        case (f)
            F_STEP:  return int'(entry_step);
            F_VALID: return int'(read_valid);
            F_BIT:   return int'(read_bit);
            F_HOLD:  return int'(state_hold);
            default: return int'(protocol_error);
        endcase
    endfunction

    // monitor: pops expected items and compares
    initial begin
        forever begin
            @(chk_ev);
            while (pend.size() > 0) begin
                item_t it;
                it = pend.pop_front();
                n_chk++;
                if (field_val(it.field) !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s field %0d actual=%0d expected=%0d",
                             it.req, it.field, field_val(it.field), it.exp);
                end
            end
        end
    end

    task automatic expect_v(string req, int f, int e);
        item_t it;
        it.req = req; it.field = f; it.exp = e;
        pend.push_back(it);
    endtask

    task automatic flush();
        #1; -> chk_ev; #1;
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0; oe_pin = 0; oe_shared = 0; i5_lvl = 0; q0_lvl = 0; sel_lvl = 0;
        tick(2);
        rst_n = 1;
        tick(1);
    endtask

    task automatic set_addr(int t);
        sel_lvl = {2'(t / 9), 2'((t / 3) % 3), 2'(t % 3)};
    endtask

    function automatic int ref_bit(int t, logic [15:0] s, logic [1:0] c);
        if (t == 0) return int'(c[1]);
        if (t == 1) return int'(s[15]);
        if (t == 2) return int'(c[0]);
        if (t == 3) return int'(s[14]);
        if (t < 18) return int'(s[t-4]);
        return 0;
    endfunction

    task automatic enter_armed(bit check);
        oe_pin = 1;
        tick(1);
        if (check) expect_v("R2", F_STEP, 1);
        if (check) flush();
        tick(G);
        q0_lvl = 2'b10;
        tick(1);
        if (check) begin
            expect_v("R3", F_STEP, 2);
            expect_v("R3", F_HOLD, 1);
            expect_v("R4", F_VALID, 0);
            expect_v("R4", F_BIT, 0);
            flush();
        end
        tick(G);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        expect_v("R1", F_STEP, 0); expect_v("R1", F_ERR, 0);
        expect_v("R1", F_VALID, 0); expect_v("R1", F_BIT, 0); expect_v("R1", F_HOLD, 0);
        flush();

        // R2 R3 R4 entry, address 0 selects cterm[1]
        state_bits = 16'hA5C3; cterm_bits = 2'b10; set_addr(0);
        enter_armed(1);
        expect_v("R4", F_VALID, 1); expect_v("R4", F_BIT, 1); expect_v("R3", F_HOLD, 1);
        flush();

        // R5 full map, two data patterns
        for (int t = 0; t < 18; t++) begin
            set_addr(t);
            expect_v("R5", F_BIT, ref_bit(t, state_bits, cterm_bits));
            flush();
            tick(1);
        end
        state_bits = 16'h3C5A; cterm_bits = 2'b01;
        for (int t = 0; t < 18; t++) begin
            set_addr(t);
            expect_v("R5", F_BIT, ref_bit(t, state_bits, cterm_bits));
            flush();
            tick(1);
        end

        // R6 unused codes
        state_bits = 16'hFFFF; cterm_bits = 2'b11;
        for (int t = 18; t < 27; t++) begin
            set_addr(t);
            expect_v("R6", F_BIT, 0);
            flush();
            tick(1);
        end

        // R13 same-cycle view, state unchanged
        set_addr(7);  // state_bits[3]
        state_bits = 16'h0000;
        expect_v("R13", F_BIT, 0); flush();
        state_bits = 16'h0008;
        expect_v("R13", F_BIT, 1); expect_v("R13", F_STEP, 2); flush();
        tick(1);
        expect_v("R13", F_STEP, 2); expect_v("R13", F_ERR, 0); flush();

        // R11 abort by q0 leaving extra-high
        q0_lvl = 2'b01;
        tick(1);
        expect_v("R11", F_STEP, 0); expect_v("R11", F_ERR, 0); expect_v("R11", F_HOLD, 0);
        flush();
        q0_lvl = 0; oe_pin = 0;
        tick(1);
        // R11 abort by oe drop in Armed
        enter_armed(0);
        oe_pin = 0;
        tick(1);
        expect_v("R11", F_STEP, 0); expect_v("R11", F_ERR, 0); flush();
        q0_lvl = 0;
        // R11 abort from OutputsOff
        oe_pin = 1; tick(1);
        oe_pin = 0; tick(1);
        expect_v("R11", F_STEP, 0); expect_v("R11", F_ERR, 0); flush();

        // R7 arm in Idle
        q0_lvl = 2'b10;
        tick(1);
        expect_v("R7", F_ERR, 1); expect_v("R7", F_STEP, 0); flush();
        // R12 sticky and sequence still usable
        q0_lvl = 0;
        tick(1);
        enter_armed(0);
        expect_v("R12", F_ERR, 1); expect_v("R12", F_STEP, 2); expect_v("R12", F_VALID, 1);
        flush();

        // R8 early arm
        do_reset();
        oe_pin = 1; tick(1);
        q0_lvl = 2'b10; tick(1);
        expect_v("R8", F_ERR, 1); expect_v("R8", F_STEP, 0); flush();

        // R9 shared pin guard
        do_reset();
        oe_shared = 1; i5_lvl = 2'b01; oe_pin = 1;
        tick(1);
        expect_v("R9", F_ERR, 1); expect_v("R9", F_STEP, 0); flush();
        do_reset();
        oe_shared = 1; i5_lvl = 2'b10; oe_pin = 1;
        tick(1);
        expect_v("R9", F_ERR, 0); expect_v("R9", F_STEP, 1); flush();

        // R10 bad level while armed
        do_reset();
        state_bits = 16'hFFFF; cterm_bits = 2'b11; set_addr(5);
        enter_armed(0);
        expect_v("R10", F_BIT, 1); flush();
        sel_lvl[3:2] = 2'b11;
        expect_v("R10", F_BIT, 0); flush();
        tick(1);
        expect_v("R10", F_ERR, 1); expect_v("R10", F_STEP, 0); expect_v("R10", F_HOLD, 0);
        flush();

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule